// File: doc/BRIEF.md
# SPI Transmit Command/Data Queue

This block is the transmit-side queue that feeds an SPI shift register. Each entry is one word that joins a per-transfer command field with a data field. A host-side write port pushes entries. The shift-register side removes the head entry with a single-cycle pop request. The queue reports a live entry count and the index of the entry that goes out next. It also reports three status flags: a fill request that DMA or interrupt logic can use, a sticky transfer-complete flag and a sticky underflow flag.

Two controls change how the storage behaves. A flush input empties the queue in one cycle. A mode input shrinks the usable capacity to a single entry, so the block works as a plain double-buffered port. In that mode the count and the flags keep the meaning they have for a depth-one queue. The serial shifting, chip-select timing, the receive path and the DMA or interrupt controllers all sit outside this block.

Top module: `spi_tx_cmd_queue`

## Requirements
- R1: A push with `push_en` high while the count is below capacity stores `{push_cmd, push_data}` and raises `entry_count` by one on the next edge. Entries leave in the order they were pushed.
- R2: A push while the count equals capacity is dropped. The count, the stored entries, the head word and all three flags behave as if no push had occurred, and no error is reported.
- R3: `pop_req` while the count is nonzero removes the head entry, lowers the count by one and advances `rd_ptr` by one, wrapping from DEPTH-1 to 0. `pop_req` while empty has no effect.
- R4: An accepted push and an accepted pop in the same cycle leave the count unchanged. Acceptance of the push is decided on the count before that edge.
- R5: `flush` empties the queue and returns both pointers to 0 on the next edge. A push or pop in the same cycle is ignored.
- R6: `fill_req` is 1 after reset. At each edge where the count is below capacity it becomes 1. When the count equals capacity, it clears on an edge where `dma_wr_done` or `clr_fill` is high, and otherwise holds.
- R7: `slave_start` while the count is 0 sets `underflow_flag`, which stays set until `clr_underflow`. When set and clear arrive together, set wins.
- R8: `xfer_end` sets `done_flag`, which stays set until `clr_done`. When set and clear arrive together, set wins.
- R9: While `fifo_off` is 1 the capacity is one entry. A second push is dropped, the count never exceeds 1, and the fill and underflow rules of R6 and R7 apply with that capacity.
- R10: During and right after reset, `entry_count` is 0, `rd_ptr` is 0, `head_valid` is 0, `fill_req` is 1, `done_flag` is 0 and `underflow_flag` is 0.
- R11: `head_valid` is 1 exactly when the count is nonzero. `head_word` then shows the oldest entry, with the command in the upper CMD_W bits and the data in the lower DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_off | input | 1 | Single-entry mode select |
| flush | input | 1 | Empty the queue |
| push_en | input | 1 | Push request |
| push_cmd | input | CMD_W | Command field of the pushed entry |
| push_data | input | DATA_W | Data field of the pushed entry |
| dma_wr_done | input | 1 | DMA write-complete indication |
| clr_fill | input | 1 | Write-one-to-clear for the fill request |
| pop_req | input | 1 | Shift register takes the head entry |
| head_valid | output | 1 | Queue holds at least one entry |
| head_word | output | CMD_W+DATA_W | Oldest entry |
| xfer_end | input | 1 | End of one serial transfer |
| slave_start | input | 1 | External master started a transfer |
| clr_done | input | 1 | Write-one-to-clear for the transfer-complete flag |
| clr_underflow | input | 1 | Write-one-to-clear for the underflow flag |
| entry_count | output | $clog2(DEPTH+1) | Number of valid entries |
| rd_ptr | output | $clog2(DEPTH) | Index of the next entry to send |
| fill_req | output | 1 | Fill request flag |
| done_flag | output | 1 | Sticky transfer-complete flag |
| underflow_flag | output | 1 | Sticky underflow flag |

## Verification
A corrupted count or pointer shows at the ports on the very next clock, either as a wrong `entry_count` or `rd_ptr` or as a `head_word` that differs from the oldest pushed entry. A wrong capacity decision shows as early or missing changes in `fill_req`. A flag that is set or cleared wrongly shows one edge after the stimulus. The reference model therefore compares every output on every cycle, under directed sequences and long mixed traffic in both modes. Divergence is caught within a cycle of the first wrong edge.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;

   // Queue operation accepted on a given edge: {push, pop}
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_POP  = 2'b01,
      OP_PUSH = 2'b10,
      OP_BOTH = 2'b11
   } txq_op_e;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 32,
   parameter int PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_word
);

   logic [WORD_W-1:0] slot [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [WORD_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == PTR_W'(i))) slot_q <= wr_word;
      end
      assign slot[i] = slot_q;
   end

   assign rd_word = slot[rd_idx];

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
   import spi_txq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int PTR_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_off,
   input  logic             flush,
   input  logic             push_req,
   input  logic             pop_req,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   logic [CNT_W-1:0] cap;
   logic [CNT_W-1:0] count_q;
   logic [PTR_W-1:0] rd_q;
   logic [PTR_W-1:0] wr_q;
   logic             acc_push;
   logic             acc_pop;
   txq_op_e          op;

   function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                input logic [CNT_W-1:0] lim);
      if ((CNT_W'(p) + CNT_W'(1)) >= lim) return '0;
      return p + PTR_W'(1);
   endfunction

   assign cap      = fifo_off ? CNT_W'(1) : CNT_W'(DEPTH);
   assign full     = (count_q >= cap);
   assign empty    = (count_q == '0);
   assign acc_push = push_req & ~full & ~flush;
   assign acc_pop  = pop_req & ~empty & ~flush;
   assign op       = txq_op_e'({acc_push, acc_pop});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         rd_q    <= '0;
         wr_q    <= '0;
      end else if (flush) begin
         count_q <= '0;
         rd_q    <= '0;
         wr_q    <= '0;
      end else begin
         unique case (op)
            OP_POP: begin
               count_q <= count_q - CNT_W'(1);
               rd_q    <= step_ptr(rd_q, cap);
            end
            OP_PUSH: begin
               count_q <= count_q + CNT_W'(1);
               wr_q    <= step_ptr(wr_q, cap);
            end
            OP_BOTH: begin
               rd_q <= step_ptr(rd_q, cap);
               wr_q <= step_ptr(wr_q, cap);
            end
            default: ;
         endcase
      end
   end

   assign wr_en  = acc_push;
   assign wr_ptr = wr_q;
   assign rd_ptr = rd_q;
   assign count  = count_q;

endmodule

// File: rtl/txq_sticky.sv
module txq_sticky #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= RST_VAL;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

endmodule

// File: rtl/txq_fill.sv
module txq_fill (
   input  logic clk,
   input  logic rst_n,
   input  logic full,
   input  logic dma_done,
   input  logic clr_i,
   output logic fill_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  fill_o <= 1'b1;
      else if (!full)              fill_o <= 1'b1;
      else if (dma_done || clr_i)  fill_o <= 1'b0;
   end

endmodule

// File: rtl/spi_tx_cmd_queue.sv
module spi_tx_cmd_queue #(
   parameter int DEPTH  = 16,
   parameter int CMD_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fifo_off,
   input  logic                        flush,
   input  logic                        push_en,
   input  logic [CMD_W-1:0]            push_cmd,
   input  logic [DATA_W-1:0]           push_data,
   input  logic                        dma_wr_done,
   input  logic                        clr_fill,
   input  logic                        pop_req,
   output logic                        head_valid,
   output logic [CMD_W+DATA_W-1:0]     head_word,
   input  logic                        xfer_end,
   input  logic                        slave_start,
   input  logic                        clr_done,
   input  logic                        clr_underflow,
   output logic [$clog2(DEPTH+1)-1:0]  entry_count,
   output logic [$clog2(DEPTH)-1:0]    rd_ptr,
   output logic                        fill_req,
   output logic                        done_flag,
   output logic                        underflow_flag
);

   localparam int WORD_W = CMD_W + DATA_W;
   localparam int PTR_W  = $clog2(DEPTH);
   localparam int CNT_W  = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_tx_cmd_queue: DEPTH must be at least 2");
   end
   if (CMD_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("spi_tx_cmd_queue: field widths must be positive");
   end

   logic             wr_en;
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_idx;
   logic [CNT_W-1:0] count;
   logic             full;
   logic             empty;

   txq_ctrl #(
      .DEPTH (DEPTH),
      .PTR_W (PTR_W),
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_off (fifo_off),
      .flush    (flush),
      .push_req (push_en),
      .pop_req  (pop_req),
      .wr_en    (wr_en),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_idx),
      .count    (count),
      .full     (full),
      .empty    (empty)
   );

   txq_store #(
      .DEPTH  (DEPTH),
      .WORD_W (WORD_W),
      .PTR_W  (PTR_W)
   ) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_ptr),
      .wr_word ({push_cmd, push_data}),
      .rd_idx  (rd_idx),
      .rd_word (head_word)
   );

   txq_fill u_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .full     (full),
      .dma_done (dma_wr_done),
      .clr_i    (clr_fill),
      .fill_o   (fill_req)
   );

   txq_sticky #(.RST_VAL(1'b0)) u_done (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (xfer_end),
      .clr_i  (clr_done),
      .flag_o (done_flag)
   );

   txq_sticky #(.RST_VAL(1'b0)) u_under (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (slave_start & empty),
      .clr_i  (clr_underflow),
      .flag_o (underflow_flag)
   );

   assign head_valid  = ~empty;
   assign entry_count = count;
   assign rd_ptr      = rd_idx;

endmodule

// File: rtl/spi_txq_chk.sv
module spi_txq_chk #(
   parameter int DEPTH = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        fifo_off,
   input logic                        flush,
   input logic                        push_en,
   input logic                        pop_req,
   input logic                        dma_wr_done,
   input logic                        slave_start,
   input logic                        xfer_end,
   input logic                        head_valid,
   input logic [$clog2(DEPTH+1)-1:0]  entry_count,
   input logic [$clog2(DEPTH)-1:0]    rd_ptr,
   input logic                        fill_req,
   input logic                        done_flag,
   input logic                        underflow_flag
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] capv;
   assign capv = fifo_off ? CNT_W'(1) : CNT_W'(DEPTH);

   // R1
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_count <= CNT_W'(DEPTH));

   // R2
   full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && !pop_req && !flush && entry_count == capv)
      |=> $stable(entry_count));

   // R3
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push_en && !flush && entry_count != '0)
      |=> entry_count == $past(entry_count) - CNT_W'(1));

   // R5
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (entry_count == '0 && rd_ptr == '0 && !head_valid));

   // R6
   fill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_count < capv) |=> fill_req);

   // R6
   fill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_count == capv && dma_wr_done) |=> !fill_req);

   // R7
   underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_start && entry_count == '0) |=> underflow_flag);

   // R8
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |=> done_flag);

   // R9
   single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_off && entry_count <= CNT_W'(1)) |=> entry_count <= CNT_W'(1));

   // R11
   valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid == (entry_count != '0));

endmodule

bind spi_tx_cmd_queue spi_txq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fifo_off       (fifo_off),
   .flush          (flush),
   .push_en        (push_en),
   .pop_req        (pop_req),
   .dma_wr_done    (dma_wr_done),
   .slave_start    (slave_start),
   .xfer_end       (xfer_end),
   .head_valid     (head_valid),
   .entry_count    (entry_count),
   .rd_ptr         (rd_ptr),
   .fill_req       (fill_req),
   .done_flag      (done_flag),
   .underflow_flag (underflow_flag)
);

// File: tb/sim_spi_tx_cmd_queue.sv
`timescale 1ns/1ps
module sim_spi_tx_cmd_queue;
   localparam int DEPTH = 16;
   localparam int CW    = 16;
   localparam int DW    = 16;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PTR_W = $clog2(DEPTH);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, fifo_off, flush, push_en, dma_wr_done, clr_fill, pop_req;
   logic xfer_end, slave_start, clr_done, clr_underflow;
   logic [CW-1:0] push_cmd;
   logic [DW-1:0] push_data;
   logic head_valid, fill_req, done_flag, underflow_flag;
   logic [CW+DW-1:0] head_word;
   logic [CNT_W-1:0] entry_count;
   logic [PTR_W-1:0] rd_ptr;

   spi_tx_cmd_queue #(.DEPTH(DEPTH), .CMD_W(CW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .fifo_off(fifo_off), .flush(flush),
      .push_en(push_en), .push_cmd(push_cmd), .push_data(push_data),
      .dma_wr_done(dma_wr_done), .clr_fill(clr_fill), .pop_req(pop_req),
      .head_valid(head_valid), .head_word(head_word), .xfer_end(xfer_end),
      .slave_start(slave_start), .clr_done(clr_done), .clr_underflow(clr_underflow),
      .entry_count(entry_count), .rd_ptr(rd_ptr), .fill_req(fill_req),
      .done_flag(done_flag), .underflow_flag(underflow_flag));

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit started = 0;
   string phase = "R10 reset";

   // behavioural reference model
   logic [31:0] mq[$];
   int  m_rp;
   bit  m_fill, m_done, m_under;

   always @(posedge clk) begin
      int  cap;
      bit  is_full, do_push, do_pop;
      if (!rst_n) begin
         mq.delete();
         m_rp = 0; m_fill = 1; m_done = 0; m_under = 0;
      end else begin
         cap     = fifo_off ? 1 : DEPTH;
         is_full = (mq.size() >= cap);
         if (!is_full) m_fill = 1;
         else if (dma_wr_done || clr_fill) m_fill = 0;
         if (slave_start && mq.size() == 0) m_under = 1;
         else if (clr_underflow) m_under = 0;
         if (xfer_end) m_done = 1;
         else if (clr_done) m_done = 0;
         if (flush) begin
            mq.delete();
            m_rp = 0;
         end else begin
            do_pop  = pop_req && mq.size() > 0;
            do_push = push_en && !is_full;
            if (do_pop) begin
               void'(mq.pop_front());
               m_rp = fifo_off ? 0 : (m_rp + 1) % DEPTH;
            end
            if (do_push) mq.push_back({push_cmd, push_data});
         end
      end
      started = 1;
   end

   task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         chk("entry_count", 64'(entry_count), 64'(mq.size()));
         if (!fifo_off) chk("rd_ptr", 64'(rd_ptr), 64'(m_rp));
         chk("fill_req", 64'(fill_req), 64'(m_fill));
         chk("done_flag", 64'(done_flag), 64'(m_done));
         chk("underflow_flag", 64'(underflow_flag), 64'(m_under));
         chk("head_valid", 64'(head_valid), 64'(mq.size() != 0));
         if (mq.size() != 0) chk("head_word", 64'(head_word), 64'(mq[0]));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 50000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic idle_inputs();
      flush = 0; push_en = 0; pop_req = 0; dma_wr_done = 0; clr_fill = 0;
      xfer_end = 0; slave_start = 0; clr_done = 0; clr_underflow = 0;
   endtask

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_n(int n, logic [15:0] base);
      for (int i = 0; i < n; i++) begin
         push_en = 1; push_cmd = 16'hC000 ^ base ^ 16'(i);
         push_data = base + 16'(i * 257);
         tick();
      end
      push_en = 0;
   endtask

   task automatic random_run(int n, bit off);
      for (int i = 0; i < n; i++) begin
         push_en       = ($urandom % 3) != 0;
         pop_req       = ($urandom % 2) != 0;
         push_cmd      = 16'($urandom);
         push_data     = 16'($urandom);
         dma_wr_done   = ($urandom % 5) == 0;
         clr_fill      = ($urandom % 9) == 0;
         slave_start   = ($urandom % 6) == 0;
         xfer_end      = ($urandom % 7) == 0;
         clr_done      = ($urandom % 5) == 0;
         clr_underflow = ($urandom % 5) == 0;
         flush         = ($urandom % 40) == 0;
         fifo_off      = off;
         tick();
      end
      idle_inputs();
   endtask

   initial begin
      rst_n = 0; fifo_off = 0; push_cmd = '0; push_data = '0;
      idle_inputs();
      tick(3);
      phase = "R10 reset";
      chk("reset count", 64'(entry_count), 64'd0);
      chk("reset fill", 64'(fill_req), 64'd1);
      rst_n = 1;
      tick(2);

      phase = "R1 fill in order";
      push_n(DEPTH, 16'h1100);
      tick();

      phase = "R2 push to full dropped";
      push_n(3, 16'h7700);
      tick();

      phase = "R6 dma done while full";
      dma_wr_done = 1; tick(); dma_wr_done = 0;
      tick(2);

      phase = "R3/R11 drain with wrap";
      pop_req = 1; tick(DEPTH + 2); pop_req = 0;
      tick();

      phase = "R6 clear by write while full";
      push_n(DEPTH, 16'h2200);
      clr_fill = 1; tick(); clr_fill = 0;
      tick();

      phase = "R4 push and pop together";
      pop_req = 1; tick(4); pop_req = 0;
      for (int i = 0; i < 6; i++) begin
         push_en = 1; pop_req = 1; push_cmd = 16'hAB00 + 16'(i); push_data = 16'(i);
         tick();
      end
      idle_inputs();
      tick();

      phase = "R5 flush beats push and pop";
      flush = 1; push_en = 1; pop_req = 1; tick();
      idle_inputs(); tick(2);

      phase = "R7 underflow sticky";
      slave_start = 1; tick();
      clr_underflow = 1; tick();
      slave_start = 0; tick();
      clr_underflow = 0; push_n(1, 16'h3300);
      slave_start = 1; tick(); slave_start = 0; tick();

      phase = "R8 transfer complete sticky";
      xfer_end = 1; tick();
      clr_done = 1; tick();
      xfer_end = 0; tick();
      clr_done = 0; tick();

      phase = "R4/R7/R8 mixed traffic";
      random_run(600, 1'b0);

      phase = "R9 single entry mode";
      flush = 1; fifo_off = 1; tick(); flush = 0;
      push_n(3, 16'h4400);
      tick();
      dma_wr_done = 1; tick(); dma_wr_done = 0;
      pop_req = 1; tick(2); pop_req = 0;
      slave_start = 1; tick(); slave_start = 0;
      random_run(400, 1'b1);

      phase = "R5 leave single mode";
      fifo_off = 1; flush = 1; tick();
      fifo_off = 0; flush = 0; tick();
      push_n(5, 16'h5500);
      random_run(300, 1'b0);
      tick(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule